// File: doc/BRIEF.md
# Configuration Window Decoder

This block sits on a processor-side memory bus and claims the accesses that land in a programmable window of the address space reserved for PCI Express configuration. The window size is a power of two from 1 MiB to 256 MiB. The base must be aligned to that size. Inside the window, the offset from the base names a target: 9 bits of bus, 8 bits of device and function, and 12 bits of register offset.

A function table is loaded through the control side. For each function it records whether that function exists and whether its configuration space is 256 or 4096 bytes. A legal access to an existing function, inside its space, goes out on a select-style config port toward the endpoint models. Every other access in the window is completed inside the block. Such a read returns all ones and such a write is dropped. An access outside the window gets a no-hit response, so that another decoder may claim it.

Every request gets its response exactly one cycle later. The window is changed by an update strobe. The update always tears down the current mapping, then maps the new base and size only when enabled and legal.

Top module: `ecam_window_top`

## Requirements
- R1: While reset is held and right after it, the window is unmapped: `rspValid` is 0 during reset, and every request after reset answers with `rspHit` = 0 until a legal update maps the window.
- R2: With the window mapped, an address hits when base <= address < base + size. A request that misses answers with `rspHit` = 0, never asserts `cfgSel`, and a missed read returns all ones.
- R3: For a hit, the offset from the base is split as bus = bits 28..20, device/function = bits 19..12 (device 19..15, function 14..12) and register offset = bits 11..0. The three fields appear on `cfgBus`, `cfgDevFn` and `cfgOffset`, together with `cfgLen`, `cfgWdata` and `cfgWrite`.
- R4: An update with `ctlEnable` = 1 maps the window only if `ctlSize` is a power of two, is at least 2^20 and at most 2^28, and `ctlBase` is a multiple of `ctlSize`. Otherwise the window is left unmapped.
- R5: Every update first unmaps the current window. With `ctlEnable` = 0 the window stays unmapped, and a remap to a new base stops the old range from hitting. A request issued in the same cycle as an update is decoded with the mapping in force before it.
- R6: A hit whose bus/device/function has no present entry in the table answers with `rspHit` = 1 and does not assert `cfgSel`. A read returns all ones and a write changes nothing.
- R7: For a present function marked small (`tblExt` = 0), offsets 256..4095 are completed locally in the same way as R6. For a function marked extended (`tblExt` = 1), every offset 0..4095 is forwarded.
- R8: Only byte lengths 1, 2 and 4 are forwarded. Any other `reqLen` on an otherwise valid hit is completed locally, and a read then returns all ones.
- R9: `rspValid` rises exactly one cycle after `reqValid`. A forwarded read returns the `cfgRdata` presented in the request cycle, and any write returns read data 0.
- R10: `tblWr` writes the entry at index {bus bit 0, devfn} (bus 0 at 0..255, bus 1 at 256..511) with `tblPresent` and `tblExt`. Buses 2 and above have no entries and are always absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlUpdate | input | 1 | Window update strobe |
| ctlEnable | input | 1 | Map after unmapping when set |
| ctlBase | input | 32 | New window base |
| ctlSize | input | 32 | New window size in bytes |
| tblWr | input | 1 | Function table write strobe |
| tblIdx | input | 9 | Table index {bus bit 0, devfn} |
| tblPresent | input | 1 | Function exists |
| tblExt | input | 1 | Function has 4096-byte space |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request byte address |
| reqWdata | input | 32 | Write data |
| reqLen | input | 3 | Byte length |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspHit | output | 1 | Request fell inside the window |
| rspRdata | output | 32 | Read data |
| cfgSel | output | 1 | Forward strobe to endpoint |
| cfgWrite | output | 1 | Forwarded access is a write |
| cfgBus | output | 9 | Target bus |
| cfgDevFn | output | 8 | Target device/function |
| cfgOffset | output | 12 | Register offset |
| cfgLen | output | 3 | Byte length |
| cfgWdata | output | 32 | Write data to endpoint |
| cfgRdata | input | 32 | Endpoint read data, same cycle as `cfgSel` |

## Verification
Reads and writes are placed on each side of both window edges and under several mappings (256 MiB, 1 MiB, and a remap to another base). This separates the range comparison from the offset masking. Targets are chosen as present-small, present-extended, absent, and on a bus beyond the table, with offsets just below and at 256. This tells forwarding apart from local completion, and it shows a wrong field split through the data returned by the endpoint model, which encodes the fields it received. Illegal sizes, a misaligned base, disabled updates and a request coincident with an update probe the mapping rules.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int BUS_W = 9;
  localparam int DEVFN_W = 8;
  localparam int OFS_W = 12;
  localparam int BUS_LSB = 20;
  localparam int DEVFN_LSB = 12;
  localparam int SMALL_SPACE_LOG2 = 8;
  localparam int WIN_MIN_LOG2 = 20;
  localparam int WIN_MAX_LOG2 = 28;

  // strobes from control to datapath, one set per request cycle
  typedef struct packed {
    logic acc;
    logic hit;
    logic fwd;
    logic wr;
  } ecamStrobe_t;
endpackage

// File: rtl/ecam_ctrl.sv
module ecam_ctrl
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 3,
  parameter int TBL_BUSES = 2,
  parameter int TBL_IDX_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlUpdate,
  input  logic                 ctlEnable,
  input  logic [ADDR_W-1:0]    ctlBase,
  input  logic [ADDR_W-1:0]    ctlSize,
  input  logic                 tblWr,
  input  logic [TBL_IDX_W-1:0] tblIdx,
  input  logic                 tblPresent,
  input  logic                 tblExt,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [BUS_W-1:0]     fldBus,
  input  logic [DEVFN_W-1:0]   fldDevFn,
  input  logic [OFS_W-1:0]     fldOfs,
  output logic [ADDR_W-1:0]    winMask,
  output ecamStrobe_t          stb
);
  localparam int TBL_DEPTH = 1 << TBL_IDX_W;
  localparam int BIDX_W = TBL_IDX_W - DEVFN_W;
  localparam logic [ADDR_W-1:0] MIN_SIZE = ADDR_W'(1) << WIN_MIN_LOG2;
  localparam logic [ADDR_W-1:0] MAX_SIZE = ADDR_W'(1) << WIN_MAX_LOG2;

  logic              winMapped;
  logic [ADDR_W-1:0] winBase;
  logic [ADDR_W-1:0] sizeLess1;
  logic              sizePow2, sizeInRange, baseAligned, sizeOk;

  // legality of a requested mapping
  always_comb begin
    sizeLess1   = ctlSize - 1'b1;
    sizePow2    = (ctlSize != '0) && ((ctlSize & sizeLess1) == '0);
    sizeInRange = (ctlSize >= MIN_SIZE) && (ctlSize <= MAX_SIZE);
    baseAligned = (ctlBase & sizeLess1) == '0;
    sizeOk      = sizePow2 && sizeInRange && baseAligned;
  end

  // an update always drops the old window, then maybe installs a new one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winMapped <= 1'b0;
      winBase   <= '0;
      winMask   <= '0;
    end else if (ctlUpdate) begin
      winMapped <= ctlEnable && sizeOk;
      if (ctlEnable && sizeOk) begin
        winBase <= ctlBase;
        winMask <= sizeLess1;
      end
    end
  end

  // function table: one present bit and one extended-space bit per entry
  logic [TBL_DEPTH-1:0] tblPres;
  logic [TBL_DEPTH-1:0] tblBig;

  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblPres[e] <= 1'b0;
        tblBig[e]  <= 1'b0;
      end else if (tblWr && (tblIdx == TBL_IDX_W'(e))) begin
        tblPres[e] <= tblPresent;
        tblBig[e]  <= tblExt;
      end
    end
  end

  logic                 winHit;
  logic                 busInTbl;
  logic [TBL_IDX_W-1:0] lkIdx;
  logic                 fnPresent, ofsInSpace, lenLegal;

  always_comb begin
    winHit     = winMapped && ((reqAddr & ~winMask) == winBase);
    busInTbl   = fldBus < BUS_W'(TBL_BUSES);
    lkIdx      = {fldBus[BIDX_W-1:0], fldDevFn};
    fnPresent  = busInTbl && tblPres[lkIdx];
    ofsInSpace = tblBig[lkIdx] || (fldOfs[OFS_W-1:SMALL_SPACE_LOG2] == '0);
    lenLegal   = (reqLen == LEN_W'(1)) || (reqLen == LEN_W'(2)) || (reqLen == LEN_W'(4));
    stb.acc    = reqValid;
    stb.hit    = reqValid && winHit;
    stb.fwd    = reqValid && winHit && fnPresent && ofsInSpace && lenLegal;
    stb.wr     = reqWrite;
  end
endmodule

// File: rtl/ecam_datapath.sv
module ecam_datapath
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [ADDR_W-1:0]  winMask,
  input  ecamStrobe_t        stb,
  output logic [BUS_W-1:0]   fldBus,
  output logic [DEVFN_W-1:0] fldDevFn,
  output logic [OFS_W-1:0]   fldOfs,
  output logic               cfgSel,
  output logic               cfgWrite,
  output logic [BUS_W-1:0]   cfgBus,
  output logic [DEVFN_W-1:0] cfgDevFn,
  output logic [OFS_W-1:0]   cfgOffset,
  output logic [LEN_W-1:0]   cfgLen,
  output logic [DATA_W-1:0]  cfgWdata,
  input  logic [DATA_W-1:0]  cfgRdata,
  output logic               rspValid,
  output logic               rspHit,
  output logic [DATA_W-1:0]  rspRdata
);
  logic [ADDR_W-1:0] winOfs;

  // field split on the offset inside the window
  always_comb begin
    winOfs   = reqAddr & winMask;
    fldBus   = BUS_W'(winOfs >> BUS_LSB);
    fldDevFn = DEVFN_W'(winOfs >> DEVFN_LSB);
    fldOfs   = OFS_W'(winOfs);
  end

  always_comb begin
    cfgSel    = stb.fwd;
    cfgWrite  = stb.fwd && stb.wr;
    cfgBus    = fldBus;
    cfgDevFn  = fldDevFn;
    cfgOffset = fldOfs;
    cfgLen    = reqLen;
    cfgWdata  = reqWdata;
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    if (!stb.acc || stb.wr) rdNext = '0;
    else if (stb.fwd)       rdNext = cfgRdata;
    else                    rdNext = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= stb.acc;
      rspHit   <= stb.hit;
      rspRdata <= rdNext;
    end
  end
endmodule

// File: rtl/ecam_window_top.sv
module ecam_window_top
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W = 3,
  parameter int TBL_BUSES = 2,
  localparam int TBL_IDX_W = ((TBL_BUSES > 1) ? $clog2(TBL_BUSES) : 1) + DEVFN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlUpdate,
  input  logic                 ctlEnable,
  input  logic [ADDR_W-1:0]    ctlBase,
  input  logic [ADDR_W-1:0]    ctlSize,
  input  logic                 tblWr,
  input  logic [TBL_IDX_W-1:0] tblIdx,
  input  logic                 tblPresent,
  input  logic                 tblExt,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [LEN_W-1:0]     reqLen,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 cfgSel,
  output logic                 cfgWrite,
  output logic [BUS_W-1:0]     cfgBus,
  output logic [DEVFN_W-1:0]   cfgDevFn,
  output logic [OFS_W-1:0]     cfgOffset,
  output logic [LEN_W-1:0]     cfgLen,
  output logic [DATA_W-1:0]    cfgWdata,
  input  logic [DATA_W-1:0]    cfgRdata
);
  ecamStrobe_t          stb;
  logic [ADDR_W-1:0]    winMask;
  logic [BUS_W-1:0]     fldBus;
  logic [DEVFN_W-1:0]   fldDevFn;
  logic [OFS_W-1:0]     fldOfs;

  ecam_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TBL_BUSES(TBL_BUSES), .TBL_IDX_W(TBL_IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlUpdate(ctlUpdate), .ctlEnable(ctlEnable), .ctlBase(ctlBase), .ctlSize(ctlSize),
    .tblWr(tblWr), .tblIdx(tblIdx), .tblPresent(tblPresent), .tblExt(tblExt),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .fldBus(fldBus), .fldDevFn(fldDevFn), .fldOfs(fldOfs),
    .winMask(winMask), .stb(stb)
  );

  ecam_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLen(reqLen),
    .winMask(winMask), .stb(stb),
    .fldBus(fldBus), .fldDevFn(fldDevFn), .fldOfs(fldOfs),
    .cfgSel(cfgSel), .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn),
    .cfgOffset(cfgOffset), .cfgLen(cfgLen), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .rspValid(rspValid), .rspHit(rspHit), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/ecam_window_chk.sv
module ecam_window_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlUpdate,
  input logic              ctlEnable,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              rspHit,
  input logic [DATA_W-1:0] rspRdata,
  input logic              cfgSel,
  input logic              cfgWrite,
  input logic [LEN_W-1:0]  cfgLen,
  input logic [DATA_W-1:0] cfgRdata
);
  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R9
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel && !cfgWrite) |=> (rspRdata == $past(cfgRdata)));
  // R9
  wr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == '0));
  // R8
  len_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |-> (cfgLen == LEN_W'(1) || cfgLen == LEN_W'(2) || cfgLen == LEN_W'(4)));
  // R6
  local_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !cfgSel) |=> (rspRdata == '1));
  // R2
  sel_implies_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |=> rspHit);
  // R5
  unmap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctlUpdate && !ctlEnable) && reqValid) |=> !rspHit);
endmodule

bind ecam_window_top ecam_window_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlUpdate(ctlUpdate), .ctlEnable(ctlEnable),
  .reqValid(reqValid), .reqWrite(reqWrite), .rspValid(rspValid), .rspHit(rspHit),
  .rspRdata(rspRdata), .cfgSel(cfgSel), .cfgWrite(cfgWrite), .cfgLen(cfgLen),
  .cfgRdata(cfgRdata)
);

// File: tb/ecam_window_top_bench.sv
module ecam_window_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlUpdate = 1'b0, ctlEnable = 1'b0;
  logic [31:0] ctlBase = '0, ctlSize = '0;
  logic        tblWr = 1'b0;
  logic [8:0]  tblIdx = '0;
  logic        tblPresent = 1'b0, tblExt = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [2:0]  reqLen = 3'd4;
  logic        rspValid, rspHit;
  logic [31:0] rspRdata;
  logic        cfgSel, cfgWrite;
  logic [8:0]  cfgBus;
  logic [7:0]  cfgDevFn;
  logic [11:0] cfgOffset;
  logic [2:0]  cfgLen;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata;

  always #2 clk = ~clk;

  // endpoint model: answers with the fields it received
  assign cfgRdata = {cfgDevFn, cfgOffset, 4'h5, cfgBus[7:0]};

  ecam_window_top u_ecam_window_top (
    .clk(clk), .rstN(rstN), .ctlUpdate(ctlUpdate), .ctlEnable(ctlEnable),
    .ctlBase(ctlBase), .ctlSize(ctlSize), .tblWr(tblWr), .tblIdx(tblIdx),
    .tblPresent(tblPresent), .tblExt(tblExt), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLen(reqLen), .rspValid(rspValid),
    .rspHit(rspHit), .rspRdata(rspRdata), .cfgSel(cfgSel), .cfgWrite(cfgWrite),
    .cfgBus(cfgBus), .cfgDevFn(cfgDevFn), .cfgOffset(cfgOffset), .cfgLen(cfgLen),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  // reference model state
  bit             mMapped = 1'b0;
  longint unsigned mBase = 0, mSize = 0;
  bit             mPres[512];
  bit             mBig[512];
  bit             eValid = 1'b0, eHit = 1'b0;
  logic [31:0]    eData = '0;
  string          eTag = "R1";

  task automatic chk(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit upd, bit en, logic [31:0] base, logic [31:0] size,
                       bit tw, int tix, bit tp, bit te,
                       bit rv, bit rw, logic [31:0] addr, logic [31:0] wd, int len);
    longint unsigned ofs;
    int bus, devfn, off, idx;
    bit hit, pres, big, fwd, legal;
    @(negedge clk);
    // response for the previous cycle's request
    chk(rspValid == eValid, eTag, "rspValid", rspValid, eValid);
    chk(rspHit == eHit, eTag, "rspHit", rspHit, eHit);
    chk(rspRdata == eData, eTag, "rspRdata", rspRdata, eData);
    ctlUpdate = upd; ctlEnable = en; ctlBase = base; ctlSize = size;
    tblWr = tw; tblIdx = 9'(tix); tblPresent = tp; tblExt = te;
    reqValid = rv; reqWrite = rw; reqAddr = addr; reqWdata = wd; reqLen = 3'(len);
    #1;
    hit = mMapped && (longint'(addr) >= mBase) && (longint'(addr) < mBase + mSize);
    ofs = longint'(addr) - mBase;
    bus = int'((ofs >> 20) & 64'h1ff);
    devfn = int'((ofs >> 12) & 64'hff);
    off = int'(ofs & 64'hfff);
    idx = (bus % 2) * 256 + devfn;
    pres = hit && (bus < 2) && mPres[idx];
    big = pres && mBig[idx];
    fwd = rv && hit && pres && (big || off < 256) && (len == 1 || len == 2 || len == 4);
    chk(cfgSel == fwd, tag, "cfgSel", cfgSel, fwd);
    if (fwd) begin
      chk(cfgBus == 9'(bus), tag, "cfgBus", cfgBus, bus);
      chk(cfgDevFn == 8'(devfn), tag, "cfgDevFn", cfgDevFn, devfn);
      chk(cfgOffset == 12'(off), tag, "cfgOffset", cfgOffset, off);
      chk(cfgLen == 3'(len), tag, "cfgLen", cfgLen, len);
      chk(cfgWrite == rw, tag, "cfgWrite", cfgWrite, rw);
      if (rw) chk(cfgWdata == wd, tag, "cfgWdata", cfgWdata, wd);
    end
    eValid = rv;
    eHit = rv && hit;
    if (!rv || rw) eData = '0;
    else if (fwd) eData = {8'(devfn), 12'(off), 4'h5, 8'(bus)};
    else eData = '1;
    eTag = tag;
    if (tw) begin mPres[tix] = tp; mBig[tix] = te; end
    if (upd) begin
      legal = (size != 0) && ((size & (size - 1)) == 0) && (size >= 32'h0010_0000)
              && (size <= 32'h1000_0000) && ((base % size) == 0);
      mMapped = 1'b0;
      if (en && legal) begin mMapped = 1'b1; mBase = base; mSize = size; end
    end
  endtask

  task automatic rd(string tag, logic [31:0] a, int len = 4);
    cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, a, 0, len);
  endtask
  task automatic wr(string tag, logic [31:0] a, logic [31:0] d, int len = 4);
    cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, a, d, len);
  endtask
  task automatic upd(string tag, bit en, logic [31:0] b, logic [31:0] s);
    cycle(tag, 1, en, b, s, 0, 0, 0, 0, 0, 0, 0, 0, 4);
  endtask
  task automatic tbl(int bus, int devfn, bit p, bit e);
    cycle("R10", 0, 0, 0, 0, 1, bus * 256 + devfn, p, e, 0, 0, 0, 0, 4);
  endtask
  task automatic idle(string tag);
    cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
  endtask

  function automatic logic [31:0] ea(logic [31:0] b, int bus, int devfn, int off);
    return b + (32'(bus) << 20) + (32'(devfn) << 12) + 32'(off);
  endfunction

  localparam logic [31:0] B0 = 32'hE000_0000;

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mPres[i] = 0; mBig[i] = 0; end
    // R1: outputs quiet while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      reqValid = 1'b1;
      chk(rspValid == 1'b0, "R1", "rspValid in reset", rspValid, 0);
    end
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // R1: unmapped after reset
    rd("R1", 32'h0000_0000);
    rd("R1", B0 + 32'h10);
    // R10: table load
    tbl(0, 8'h08, 1, 0);
    tbl(0, 8'h0A, 1, 1);
    tbl(1, 8'hFF, 1, 1);
    tbl(0, 8'h10, 0, 1);
    // R4: rejected mappings
    upd("R4", 1, B0, 32'h0300_0000);
    rd("R4", ea(B0, 0, 8'h08, 16));
    upd("R4", 1, B0, 32'h0008_0000);
    rd("R4", ea(B0, 0, 8'h08, 16));
    upd("R4", 1, 32'h0000_0000, 32'h2000_0000);
    rd("R4", 32'h0000_8010);
    upd("R4", 1, 32'hE010_0000, 32'h0100_0000);
    rd("R4", 32'hE010_8010);
    // legal 256 MiB window
    upd("R4", 1, B0, 32'h1000_0000);
    // R2: edges
    rd("R2", B0 - 4);
    rd("R2", 32'hF000_0000);
    rd("R2", 32'hEFFF_FFFC);
    wr("R2", B0 - 4, 32'h1234_5678);
    // R3: forwarded splits
    rd("R3", ea(B0, 0, 8'h08, 16));
    rd("R3", ea(B0, 1, 8'hFF, 12'hFFC));
    wr("R3", ea(B0, 0, 8'h0A, 12'h44), 32'hCAFE_F00D);
    rd("R3", ea(B0, 0, 8'h08, 12'h0FC), 1);
    // R7: offset against space size
    rd("R7", ea(B0, 0, 8'h08, 12'h100));
    wr("R7", ea(B0, 0, 8'h08, 12'h200), 32'h1);
    rd("R7", ea(B0, 0, 8'h0A, 12'h800));
    rd("R7", ea(B0, 0, 8'h0A, 12'hFFF), 1);
    // R6: absent functions
    rd("R6", ea(B0, 0, 8'h10, 4));
    wr("R6", ea(B0, 0, 8'h10, 4), 32'h55);
    rd("R6", ea(B0, 0, 8'h30, 0));
    // R10: bus beyond the table is absent
    rd("R10", ea(B0, 2, 8'h08, 16));
    rd("R10", ea(B0, 3, 8'hFF, 16));
    // R8: lengths
    rd("R8", ea(B0, 0, 8'h08, 16), 3);
    rd("R8", ea(B0, 0, 8'h08, 16), 2);
    wr("R8", ea(B0, 0, 8'h08, 17), 32'hAB, 1);
    wr("R8", ea(B0, 0, 8'h08, 16), 32'hAB, 0);
    // R9: back-to-back reads, write returns zero
    rd("R9", ea(B0, 1, 8'hFF, 8));
    rd("R9", ea(B0, 0, 8'h0A, 12));
    wr("R9", ea(B0, 0, 8'h0A, 12), 32'hFFFF_FFFF);
    idle("R9");
    // R5: request during disabling update uses old mapping, then unmapped
    cycle("R5", 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, ea(B0, 0, 8'h08, 16), 0, 4);
    rd("R5", ea(B0, 0, 8'h08, 16));
    // R5: 1 MiB window elsewhere; old base no longer hits
    upd("R5", 1, 32'h1000_0000, 32'h0010_0000);
    rd("R5", ea(B0, 0, 8'h08, 16));
    rd("R5", 32'h1000_8010);
    rd("R5", 32'h1010_0000);
    rd("R5", 32'h100F_FFFC);
    // R5: remap while mapped
    upd("R5", 1, 32'h2000_0000, 32'h0200_0000);
    rd("R5", 32'h1000_8010);
    rd("R5", ea(32'h2000_0000, 1, 8'hFF, 0));
    rd("R5", ea(32'h2000_0000, 1, 8'hFF, 0) + 32'h0200_0000);
    // R4: rejected update while mapped leaves it unmapped
    upd("R4", 1, 32'h2000_0000, 32'h0000_0000);
    rd("R4", ea(32'h2000_0000, 1, 8'hFF, 0));
    idle("R4");
    idle("R4");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule